// File: doc/BRIEF.md
# Banked Integer Register File with Privileged Shadow Remap

This block holds the integer registers of a 64-bit core. It has two combinational read ports and one write port. Beside the main bank of 31 writable registers it keeps a shadow bank of eight registers. While the core runs privileged firmware, a fixed, non-contiguous set of architectural indices is steered to the shadow bank. Firmware can then use those registers as scratch space without saving or disturbing the values that ordinary code left in the main bank.

A single mode input chooses the mapping on every access. Indices 8 to 14 become shadow entries 0 to 6 in order, and index 25 becomes shadow entry 7. Every other index, and every index outside privileged mode, reaches the main bank. Index 31 is the constant-zero register. Both read ports and the write port pass through the same remap.

Top module: `banked_regfile`

## Requirements
- R1: With priv_mode low, a write to any index 0 to 30 stores wr_data in the main bank, and a later read of that index with priv_mode low returns it.
- R2: With priv_mode high, indices 8 to 14 address shadow entries 0 to 6 in that order. These storage locations are separate from main registers 8 to 14.
- R3: With priv_mode high, index 25 addresses shadow entry 7, which is separate from main register 25.
- R4: With priv_mode high, every index 0 to 30 other than 8 to 14 and 25 addresses the same main register that it addresses with priv_mode low.
- R5: A read of index 31 returns zero in both modes. A write to index 31 changes no register.
- R6: A write takes effect at the rising clock edge where wr_en is high. A read of the same location in that cycle still returns the old value, and reads from the following cycle onward return the new value.
- R7: The mapping is chosen per access. A write uses the value priv_mode has at its clock edge. A read uses the current value of priv_mode combinationally.
- R8: While rst_n is low, every main and shadow register is cleared to zero, and every read returns zero.
- R9: The two read ports are independent. Each one returns the value of the location its own index selects under the current mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_mode | input | 1 | High selects the shadow remap |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 64 | Read port A data, combinational |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 64 | Read port B data, combinational |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 64 | Write data |

## Verification
The read data depends combinationally on the read index and on priv_mode, so each read result is due in the same cycle as its stimulus. The bench drives inputs just after a falling edge and compares both read ports a moment later, before the next rising edge. A write lands at the next rising edge. The reference model is therefore updated only after that edge, which means a read of the written location in the write cycle is checked against the old value (R6) and the new value is expected from the following cycle. The effect of reset is asynchronous, and the bench checks it while rst_n is still low.

// File: rtl/bregs_pkg.sv
package bregs_pkg;
  localparam int XLEN     = 64;
  localparam int IDX_W    = 5;
  localparam int ZERO_IDX = 31;
  localparam int MAIN_CNT = 31;
  // shadow remap: a contiguous run starting at SH_BASE plus one extra index
  localparam int SH_BASE  = 8;
  localparam int SH_RUN   = 7;
  localparam int SH_EXTRA = 25;
  localparam int SH_CNT   = SH_RUN + 1;
  localparam int SH_W     = $clog2(SH_CNT);

  typedef struct packed {
    logic            zero;
    logic            shadow;
    logic [SH_W-1:0] sh_idx;
  } route_t;
endpackage

// File: rtl/bregs_route.sv
module bregs_route
  import bregs_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic             priv,
  output route_t           route
);
  logic in_run;
  logic is_extra;

  always_comb begin
    in_run   = (idx >= IDX_W'(SH_BASE)) && (idx < IDX_W'(SH_BASE + SH_RUN));
    is_extra = (idx == IDX_W'(SH_EXTRA));
  end

  always_comb begin
    route        = '0;
    route.zero   = (idx == IDX_W'(ZERO_IDX));
    if (priv && in_run) begin
      route.shadow = 1'b1;
      route.sh_idx = SH_W'(idx - IDX_W'(SH_BASE));
    end else if (priv && is_extra) begin
      route.shadow = 1'b1;
      route.sh_idx = SH_W'(SH_RUN);
    end
  end
endmodule

// File: rtl/bregs_bank.sv
module bregs_bank #(
  parameter  int WIDTH = 64,
  parameter  int DEPTH = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr_a,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_a,
  output logic [WIDTH-1:0] rdata_b
);
  logic [WIDTH-1:0] mem [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic             en;
    logic [WIDTH-1:0] d;

    always_comb begin
      en = we && (waddr == AW'(e));
      d  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[e] <= '0;
      end else if (en) begin
        mem[e] <= d;
      end
    end
  end

  always_comb begin
    rdata_a = (int'(raddr_a) < DEPTH) ? mem[raddr_a] : '0;
    rdata_b = (int'(raddr_b) < DEPTH) ? mem[raddr_b] : '0;
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bregs_pkg::*;
#(
  parameter int DATA_W = XLEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              priv_mode,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int NPORT = 3;  // 0: read A, 1: read B, 2: write
  localparam int NRD   = 2;

  logic [IDX_W-1:0] port_idx [NPORT];
  route_t           port_rt  [NPORT];

  always_comb begin
    port_idx[0] = rd_a_idx;
    port_idx[1] = rd_b_idx;
    port_idx[2] = wr_idx;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_route
    bregs_route u_route (
      .idx   (port_idx[p]),
      .priv  (priv_mode),
      .route (port_rt[p])
    );
  end

  logic main_we;
  logic sh_we;

  always_comb begin
    main_we = wr_en && !port_rt[2].zero && !port_rt[2].shadow;
    sh_we   = wr_en && port_rt[2].shadow;
  end

  logic [DATA_W-1:0] main_q [NRD];
  logic [DATA_W-1:0] sh_q   [NRD];

  bregs_bank #(.WIDTH(DATA_W), .DEPTH(MAIN_CNT)) u_main (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (main_we),
    .waddr   (wr_idx),
    .wdata   (wr_data),
    .raddr_a (rd_a_idx),
    .raddr_b (rd_b_idx),
    .rdata_a (main_q[0]),
    .rdata_b (main_q[1])
  );

  bregs_bank #(.WIDTH(DATA_W), .DEPTH(SH_CNT)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (sh_we),
    .waddr   (port_rt[2].sh_idx),
    .wdata   (wr_data),
    .raddr_a (port_rt[0].sh_idx),
    .raddr_b (port_rt[1].sh_idx),
    .rdata_a (sh_q[0]),
    .rdata_b (sh_q[1])
  );

  logic [DATA_W-1:0] rd_mux [NRD];

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    always_comb begin
      if (port_rt[r].zero)        rd_mux[r] = '0;
      else if (port_rt[r].shadow) rd_mux[r] = sh_q[r];
      else                        rd_mux[r] = main_q[r];
    end
  end

  always_comb begin
    rd_a_data = rd_mux[0];
    rd_b_data = rd_mux[1];
  end
endmodule

// File: rtl/bregs_chk.sv
module bregs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        priv_mode,
  input logic [4:0]  rd_a_idx,
  input logic [63:0] rd_a_data,
  input logic [4:0]  rd_b_idx,
  input logic [63:0] rd_b_data,
  input logic        wr_en,
  input logic [4:0]  wr_idx,
  input logic [63:0] wr_data
);
  // storage location code: 0..31 main, 32..39 shadow
  function automatic logic [5:0] loc(input logic [4:0] i, input logic p);
    if (p && i >= 5'd8 && i <= 5'd14) return 6'd32 + 6'(i) - 6'd8;
    if (p && i == 5'd25)              return 6'd39;
    return {1'b0, i};
  endfunction

  // R5: constant zero register on both ports
  assert_zero_read_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 5'd31) |-> (rd_a_data == 64'd0));
  assert_zero_read_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == 5'd31) |-> (rd_b_data == 64'd0));

  // R6/R7: a write is visible at the next edge through the same mapping
  assert_write_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && $past(wr_idx) != 5'd31 &&
     loc(rd_a_idx, priv_mode) == loc($past(wr_idx), $past(priv_mode)))
    |-> (rd_a_data == $past(wr_data)));

  // R2/R3/R4: a write to another location leaves a held read unchanged
  assert_isolation_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && rd_b_idx == $past(rd_b_idx) && priv_mode == $past(priv_mode) &&
     (!$past(wr_en) || $past(wr_idx) == 5'd31 ||
      loc($past(wr_idx), $past(priv_mode)) != loc(rd_b_idx, priv_mode)))
    |-> $stable(rd_b_data));

  // R8: first cycle out of reset reads zero everywhere
  assert_reset_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (rd_a_data == 64'd0 && rd_b_data == 64'd0));
endmodule

bind banked_regfile bregs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .priv_mode (priv_mode),
  .rd_a_idx  (rd_a_idx),
  .rd_a_data (rd_a_data),
  .rd_b_idx  (rd_b_idx),
  .rd_b_data (rd_b_data),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_data   (wr_data)
);

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        priv_mode;
  logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [63:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en;

  int checks = 0;
  int errors = 0;

  logic [63:0] m_main [32];
  logic [63:0] m_sh   [8];

  always #10 clk = ~clk;

  banked_regfile u0 (
    .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  function automatic bit is_sh(input logic [4:0] i, input logic p);
    return p && ((i >= 5'd8 && i <= 5'd14) || i == 5'd25);
  endfunction

  function automatic int sh_of(input logic [4:0] i);
    return (i == 5'd25) ? 7 : int'(i) - 8;
  endfunction

  function automatic logic [63:0] exp_rd(input logic [4:0] i, input logic p);
    if (i == 5'd31) return 64'd0;
    if (is_sh(i, p)) return m_sh[sh_of(i)];
    return m_main[i];
  endfunction

  function automatic string tag(input logic [4:0] i, input logic p);
    if (i == 5'd31) return "R5";
    if (is_sh(i, p)) return (i == 5'd25) ? "R3" : "R2";
    return p ? "R4" : "R1";
  endfunction

  task automatic clear_model();
    for (int k = 0; k < 32; k++) m_main[k] = '0;
    for (int k = 0; k < 8; k++)  m_sh[k]   = '0;
  endtask

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // one cycle: drive after negedge, check reads, advance model at posedge
  task automatic step(input logic p, input logic [4:0] ra, input logic [4:0] rb,
                      input logic we, input logic [4:0] wi, input logic [63:0] wd,
                      input string extra);
    @(negedge clk);
    priv_mode = p; rd_a_idx = ra; rd_b_idx = rb;
    wr_en = we; wr_idx = wi; wr_data = wd;
    #2;
    chk({tag(ra, p), "/R9", extra}, rd_a_data, exp_rd(ra, p));
    chk({tag(rb, p), "/R9", extra}, rd_b_data, exp_rd(rb, p));
    @(posedge clk);
    if (we && wi != 5'd31) begin
      if (is_sh(wi, p)) m_sh[sh_of(wi)] = wd;
      else              m_main[wi]      = wd;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; priv_mode = 0; rd_a_idx = 0; rd_b_idx = 0;
    wr_en = 0; wr_idx = 0; wr_data = 0;
    clear_model();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R8: all locations read zero after reset, both modes
    for (int i = 0; i < 32; i++) begin
      step(1'b0, 5'(i), 5'(31 - i), 1'b0, 5'd0, 64'd0, "/R8");
      step(1'b1, 5'(i), 5'(31 - i), 1'b0, 5'd0, 64'd0, "/R8");
    end

    // fill main bank in normal mode (R1)
    for (int i = 0; i < 32; i++)
      step(1'b0, 5'd0, 5'd1, 1'b1, 5'(i), {32'hA0A0_0000, 32'(i)}, "/R1");
    // fill shadow via privileged writes (R2, R3) and R4 write to index 3
    for (int i = 8; i <= 14; i++)
      step(1'b1, 5'(i), 5'd25, 1'b1, 5'(i), {32'h5BAD_0000, 32'(i)}, "/R2");
    step(1'b1, 5'd25, 5'd9, 1'b1, 5'd25, 64'h5BAD_0000_0000_0019, "/R3");
    step(1'b1, 5'd3, 5'd3, 1'b1, 5'd3, 64'h0000_0000_CAFE_0003, "/R4");
    // read back all in both modes
    for (int i = 0; i < 32; i++) begin
      step(1'b0, 5'(i), 5'(i), 1'b0, 5'd0, 64'd0, "/R1");
      step(1'b1, 5'(i), 5'(i), 1'b0, 5'd0, 64'd0, "/R2R3R4");
    end

    // R6: same-cycle read of written location returns old value
    step(1'b1, 5'd10, 5'd10, 1'b1, 5'd10, 64'h1111_2222_3333_4444, "/R6");
    step(1'b1, 5'd10, 5'd10, 1'b0, 5'd0, 64'd0, "/R6");
    // R7: mode flips between write and read
    step(1'b0, 5'd10, 5'd25, 1'b1, 5'd25, 64'h7777_0000_0000_0025, "/R7");
    step(1'b1, 5'd25, 5'd10, 1'b0, 5'd0, 64'd0, "/R7");
    step(1'b0, 5'd25, 5'd10, 1'b0, 5'd0, 64'd0, "/R7");
    // R5: write to 31 discarded
    step(1'b0, 5'd31, 5'd31, 1'b1, 5'd31, 64'hFFFF_FFFF_FFFF_FFFF, "/R5");
    step(1'b1, 5'd31, 5'd31, 1'b1, 5'd31, 64'hFFFF_FFFF_FFFF_FFFF, "/R5");
    for (int i = 0; i < 32; i++)
      step(1'b0, 5'(i), 5'd31, 1'b0, 5'd0, 64'd0, "/R5");

    // random traffic biased toward the remapped indices
    for (int n = 0; n < 4000; n++) begin
      logic [4:0] ra, rb, wi;
      ra = ($urandom_range(0, 1) == 0) ? 5'($urandom_range(7, 15)) : 5'($urandom_range(0, 31));
      rb = ($urandom_range(0, 3) == 0) ? 5'd25 : 5'($urandom_range(0, 31));
      wi = ($urandom_range(0, 1) == 0) ? 5'($urandom_range(7, 15)) : 5'($urandom_range(0, 31));
      step(1'($urandom_range(0, 1)), ra, rb, 1'($urandom_range(0, 1)), wi,
           {$urandom(), $urandom()}, "/rand");
    end

    // R8: asynchronous reset mid-run clears both banks
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    #2;
    clear_model();
    for (int i = 0; i < 32; i++) begin
      priv_mode = 1'b1; rd_a_idx = 5'(i); rd_b_idx = 5'(31 - i);
      #1;
      chk("R8", rd_a_data, 64'd0);
      chk("R8", rd_b_data, 64'd0);
    end
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < 32; i++)
      step(1'b0, 5'(i), 5'd25, 1'b0, 5'd0, 64'd0, "/R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule